// File: doc/BRIEF.md
# Per-Bank Open-Row Shadow Tracker

This block keeps a shadow copy of the row-buffer state of a small array of DRAM banks. With that copy, a memory controller knows before it issues a request whether the request will hit the open row or miss. It also knows how long the device will be busy loading a new row. A controller that uses this block does not retry blindly after a negative acknowledge. It schedules the resend instead. For each bank the block holds a valid flag, a dirty flag and the number of the open row.

Only the lowest part of the address space is tracked. With the defaults this is eight banks of 1 MiB, each with a 2 KiB row. Requests above that region get a default "hit" prediction, raise an out-of-range flag and leave all state unchanged.

The tracker reports three things on a status port: the dirty flags, the valid flags and a retry timer.
- A refresh-done pulse invalidates every open row.
- A write strobe to the status register forces every bank to invalid and dirty. This state does not match the device, and software must avoid it during normal operation.
- On a predicted miss, the retry timer counts down the clean or dirty penalty and then pulses `resend`.

Top module: `row_shadow_tracker`

## Requirements
- R1: After reset all valid and dirty flags are 0, `status_rd` is 0, and `pred_valid`, `retry_pending` and `resend` are 0.
- R2: A tracked request to a bank whose valid flag is 0, or whose open row differs from the requested row, is predicted a miss with `nack_expected`=1. Afterwards the bank is valid, holds the new row and has its dirty flag cleared.
- R3: A tracked request to a valid bank with the same row is predicted a hit with `nack_expected`=0 and `retry_delay`=0. A write hit sets the bank's dirty flag.
- R4: A miss on a bank whose dirty flag is set is reported on `pred_miss_dirty` with `retry_delay`=DIRTY_DELAY. Otherwise the miss is reported on `pred_miss_clean` with `retry_delay`=CLEAN_DELAY.
- R5: A request whose line address lies at or above NUM_BANKS×2^BANK_LOG2 bytes gives `out_of_range`=1 and `pred_hit`=1, and it changes no tracking state.
- R6: `status_rd[NUM_BANKS+i]` is the dirty flag of bank i and `status_rd[i]` is its valid flag. The bank index is line address bits [BANK_LOG2-ROW_LOG2 +: log2(NUM_BANKS)], and the row is the bits below it.
- R7: A `status_wr` strobe clears every valid flag and sets every dirty flag. This takes precedence over a refresh or request in the same cycle. A request in that cycle is still predicted from the prior state.
- R8: A `refresh_done` pulse clears every valid flag and leaves the dirty flags unchanged. In the same cycle it overrides the valid flag that a request would set.
- R9: A predicted miss loads the retry timer. `retry_pending` is 1 for the next `retry_delay` cycles. `resend` pulses for one cycle exactly `retry_delay` cycles after the prediction, and a new miss reloads the timer.
- R10: While `pred_valid` is 1, exactly one of `pred_hit`, `pred_miss_clean` and `pred_miss_dirty` is 1. While it is 0, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request issue strobe |
| req_line | input | ADDR_W-ROW_LOG2 | Request byte address with the in-row column bits dropped |
| req_write | input | 1 | 1 for write, 0 for read |
| refresh_done | input | 1 | Refresh completed pulse |
| status_wr | input | 1 | Write strobe to the status register |
| pred_valid | output | 1 | Prediction outputs are valid this cycle |
| pred_hit | output | 1 | Request predicted to hit |
| pred_miss_clean | output | 1 | Request predicted to miss on a clean bank |
| pred_miss_dirty | output | 1 | Request predicted to miss on a dirty bank |
| nack_expected | output | 1 | Device expected to answer with a negative acknowledge |
| out_of_range | output | 1 | Request lies outside the tracked region |
| retry_delay | output | DELAY_W | Cycles to wait before the resend |
| retry_pending | output | 1 | Retry timer running |
| resend | output | 1 | One-cycle pulse: resend the missed request now |
| status_rd | output | 2*NUM_BANKS | Dirty flags (upper half) and valid flags (lower half) |

## Verification
The prediction outputs for a request sampled at a clock edge are registered at that edge and hold for exactly the following cycle. Bank flags and `status_rd` change at the same edge. The bench drives stimulus at a falling edge, waits for one rising edge and compares all of these at the next falling edge against a bench model that was updated with the same priority rules. The retry timer is followed cycle by cycle after a miss: `retry_pending` must be 1 for every sample up to the delay, and `resend` must be 1 only on the sample taken `retry_delay` rising edges after the prediction.

// File: rtl/row_shadow_pkg.sv
package row_shadow_pkg;
   typedef enum logic [1:0] {
      OUTC_HIT        = 2'd0,
      OUTC_MISS_CLEAN = 2'd1,
      OUTC_MISS_DIRTY = 2'd2
   } outcome_e;
endpackage

// File: rtl/rst_line_split.sv
// Splits a line address into bank index, row index and a tracked-region flag.
module rst_line_split #(
   parameter int LINE_W     = 15,
   parameter int ROW_W      = 9,
   parameter int BANK_IDX_W = 3
) (
   input  logic [LINE_W-1:0]     line_i,
   output logic [BANK_IDX_W-1:0] bank_o,
   output logic [ROW_W-1:0]      row_o,
   output logic                  in_range_o
);
   localparam int TRACK_TOP = ROW_W + BANK_IDX_W;

   assign row_o  = line_i[ROW_W-1:0];
   assign bank_o = line_i[TRACK_TOP-1:ROW_W];

   generate
      if (LINE_W > TRACK_TOP) begin : g_upper
         assign in_range_o = ~|line_i[LINE_W-1:TRACK_TOP];
      end else begin : g_full
         assign in_range_o = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/rst_bank_slot.sv
// Shadow state of one bank: valid flag, dirty flag and open row number.
module rst_bank_slot #(
   parameter int ROW_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_i,
   input  logic [ROW_W-1:0] row_i,
   input  logic             write_i,
   input  logic             inval_i,
   input  logic             force_i,
   output logic             valid_o,
   output logic             dirty_o,
   output logic             hit_o
);
   logic [ROW_W-1:0] open_row_q;
   logic             valid_q;
   logic             dirty_q;

   assign hit_o   = valid_q && (open_row_q == row_i);
   assign valid_o = valid_q;
   assign dirty_o = dirty_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q    <= 1'b0;
         dirty_q    <= 1'b0;
         open_row_q <= '0;
      end else if (force_i) begin
         valid_q <= 1'b0;
         dirty_q <= 1'b1;
      end else begin
         if (sel_i) begin
            if (hit_o) begin
               dirty_q <= dirty_q | write_i;
            end else begin
               valid_q    <= 1'b1;
               open_row_q <= row_i;
               dirty_q    <= 1'b0;
            end
         end
         if (inval_i) begin
            valid_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rst_outcome_eval.sv
// Classifies a request from the selected bank's state.
module rst_outcome_eval
   import row_shadow_pkg::*;
#(
   parameter int DELAY_W     = 8,
   parameter int CLEAN_DELAY = 6,
   parameter int DIRTY_DELAY = 9
) (
   input  logic               in_range_i,
   input  logic               bank_hit_i,
   input  logic               bank_dirty_i,
   output outcome_e           outc_o,
   output logic [DELAY_W-1:0] delay_o
);
   localparam logic [DELAY_W-1:0] CLEAN_D = DELAY_W'(CLEAN_DELAY);
   localparam logic [DELAY_W-1:0] DIRTY_D = DELAY_W'(DIRTY_DELAY);

   always_comb begin
      if (!in_range_i || bank_hit_i) begin
         outc_o  = OUTC_HIT;
         delay_o = '0;
      end else if (bank_dirty_i) begin
         outc_o  = OUTC_MISS_DIRTY;
         delay_o = DIRTY_D;
      end else begin
         outc_o  = OUTC_MISS_CLEAN;
         delay_o = CLEAN_D;
      end
   end
endmodule

// File: rtl/rst_retry_timer.sv
// Counts down a miss penalty and pulses when the resend is due.
module rst_retry_timer #(
   parameter int DELAY_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [DELAY_W-1:0] load_val_i,
   output logic               pending_o,
   output logic               fire_o
);
   logic [DELAY_W-1:0] cnt_q;
   logic               fire_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         fire_q <= 1'b0;
      end else if (load_i) begin
         cnt_q  <= load_val_i;
         fire_q <= 1'b0;
      end else begin
         fire_q <= (cnt_q == DELAY_W'(1));
         if (cnt_q != '0) begin
            cnt_q <= cnt_q - DELAY_W'(1);
         end
      end
   end

   assign pending_o = (cnt_q != '0);
   assign fire_o    = fire_q;
endmodule

// File: rtl/row_shadow_tracker.sv
module row_shadow_tracker
   import row_shadow_pkg::*;
#(
   parameter int NUM_BANKS   = 8,
   parameter int ADDR_W      = 26,
   parameter int BANK_LOG2   = 20,
   parameter int ROW_LOG2    = 11,
   parameter int DELAY_W     = 8,
   parameter int CLEAN_DELAY = 6,
   parameter int DIRTY_DELAY = 9,
   localparam int LINE_W     = ADDR_W - ROW_LOG2,
   localparam int STAT_W     = 2 * NUM_BANKS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [LINE_W-1:0]  req_line,
   input  logic               req_write,
   input  logic               refresh_done,
   input  logic               status_wr,
   output logic               pred_valid,
   output logic               pred_hit,
   output logic               pred_miss_clean,
   output logic               pred_miss_dirty,
   output logic               nack_expected,
   output logic               out_of_range,
   output logic [DELAY_W-1:0] retry_delay,
   output logic               retry_pending,
   output logic               resend,
   output logic [STAT_W-1:0]  status_rd
);
   localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int ROW_W      = BANK_LOG2 - ROW_LOG2;

   initial begin
      if ((1 << BANK_IDX_W) != NUM_BANKS)
         $fatal(1, "NUM_BANKS must be a power of two of at least 2");
      if (LINE_W < ROW_W + BANK_IDX_W)
         $fatal(1, "ADDR_W too small for the tracked region");
      if (CLEAN_DELAY < 1 || DIRTY_DELAY < 1)
         $fatal(1, "retry delays must be at least 1");
      if (CLEAN_DELAY >= (1 << DELAY_W) || DIRTY_DELAY >= (1 << DELAY_W))
         $fatal(1, "retry delays do not fit DELAY_W");
   end

   logic [BANK_IDX_W-1:0] bank_idx;
   logic [ROW_W-1:0]      row_idx;
   logic                  in_range;

   rst_line_split #(
      .LINE_W     (LINE_W),
      .ROW_W      (ROW_W),
      .BANK_IDX_W (BANK_IDX_W)
   ) split_i (
      .line_i     (req_line),
      .bank_o     (bank_idx),
      .row_o      (row_idx),
      .in_range_o (in_range)
   );

   logic [NUM_BANKS-1:0] valid_vec;
   logic [NUM_BANKS-1:0] dirty_vec;
   logic [NUM_BANKS-1:0] hit_vec;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic sel;
         assign sel = req_valid && in_range && (bank_idx == BANK_IDX_W'(b));
         rst_bank_slot #(.ROW_W(ROW_W)) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_i   (sel),
            .row_i   (row_idx),
            .write_i (req_write),
            .inval_i (refresh_done),
            .force_i (status_wr),
            .valid_o (valid_vec[b]),
            .dirty_o (dirty_vec[b]),
            .hit_o   (hit_vec[b])
         );
      end
   endgenerate

   outcome_e           outc;
   logic [DELAY_W-1:0] delay_nxt;

   rst_outcome_eval #(
      .DELAY_W     (DELAY_W),
      .CLEAN_DELAY (CLEAN_DELAY),
      .DIRTY_DELAY (DIRTY_DELAY)
   ) eval_i (
      .in_range_i   (in_range),
      .bank_hit_i   (hit_vec[bank_idx]),
      .bank_dirty_i (dirty_vec[bank_idx]),
      .outc_o       (outc),
      .delay_o      (delay_nxt)
   );

   logic is_miss;
   assign is_miss = req_valid && (outc != OUTC_HIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pred_valid      <= 1'b0;
         pred_hit        <= 1'b0;
         pred_miss_clean <= 1'b0;
         pred_miss_dirty <= 1'b0;
         nack_expected   <= 1'b0;
         out_of_range    <= 1'b0;
         retry_delay     <= '0;
      end else begin
         pred_valid      <= req_valid;
         pred_hit        <= req_valid && (outc == OUTC_HIT);
         pred_miss_clean <= req_valid && (outc == OUTC_MISS_CLEAN);
         pred_miss_dirty <= req_valid && (outc == OUTC_MISS_DIRTY);
         nack_expected   <= is_miss;
         out_of_range    <= req_valid && !in_range;
         retry_delay     <= req_valid ? delay_nxt : '0;
      end
   end

   rst_retry_timer #(.DELAY_W(DELAY_W)) timer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (is_miss),
      .load_val_i (delay_nxt),
      .pending_o  (retry_pending),
      .fire_o     (resend)
   );

   assign status_rd = {dirty_vec, valid_vec};
endmodule

// File: rtl/row_shadow_tracker_chk.sv
module row_shadow_tracker_chk #(
   parameter int NUM_BANKS   = 8,
   parameter int DELAY_W     = 8,
   parameter int DIRTY_DELAY = 9
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   refresh_done,
   input logic                   status_wr,
   input logic                   pred_valid,
   input logic                   pred_hit,
   input logic                   pred_miss_clean,
   input logic                   pred_miss_dirty,
   input logic                   nack_expected,
   input logic                   out_of_range,
   input logic [DELAY_W-1:0]     retry_delay,
   input logic                   retry_pending,
   input logic                   resend,
   input logic [2*NUM_BANKS-1:0] status_rd
);
   // R10
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pred_valid |-> ($countones({pred_hit, pred_miss_clean, pred_miss_dirty}) == 1));
   // R10
   idle_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_valid |-> ($countones({pred_hit, pred_miss_clean, pred_miss_dirty}) == 0));
   // R2
   miss_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_miss_clean || pred_miss_dirty) |-> nack_expected);
   // R3
   hit_no_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pred_hit |-> (!nack_expected && retry_delay == '0));
   // R4
   dirty_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pred_miss_dirty |-> (retry_delay == DELAY_W'(DIRTY_DELAY)));
   // R5
   oor_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_of_range |-> pred_hit);
   // R7
   force_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_wr |=> (status_rd == {{NUM_BANKS{1'b1}}, {NUM_BANKS{1'b0}}}));
   // R8
   refresh_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_done && !status_wr) |=> (status_rd[NUM_BANKS-1:0] == '0));
   // R9
   miss_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_miss_clean || pred_miss_dirty) |-> retry_pending);
   // R9
   resend_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resend |-> $past(retry_pending));
endmodule

bind row_shadow_tracker row_shadow_tracker_chk #(
   .NUM_BANKS   (NUM_BANKS),
   .DELAY_W     (DELAY_W),
   .DIRTY_DELAY (DIRTY_DELAY)
) chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .refresh_done    (refresh_done),
   .status_wr       (status_wr),
   .pred_valid      (pred_valid),
   .pred_hit        (pred_hit),
   .pred_miss_clean (pred_miss_clean),
   .pred_miss_dirty (pred_miss_dirty),
   .nack_expected   (nack_expected),
   .out_of_range    (out_of_range),
   .retry_delay     (retry_delay),
   .retry_pending   (retry_pending),
   .resend          (resend),
   .status_rd       (status_rd)
);

// File: tb/row_shadow_tracker_tb_top.sv
`timescale 1ns/1ps
module row_shadow_tracker_tb_top;
   localparam int NB     = 8;
   localparam int LINE_W = 15;
   localparam int CLEAN  = 6;
   localparam int DIRTY  = 9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [LINE_W-1:0] req_line = '0;
   logic              req_write = 1'b0;
   logic              refresh_done = 1'b0;
   logic              status_wr = 1'b0;
   logic              pred_valid, pred_hit, pred_miss_clean, pred_miss_dirty;
   logic              nack_expected, out_of_range, retry_pending, resend;
   logic [7:0]        retry_delay;
   logic [2*NB-1:0]   status_rd;

   always #2 clk = ~clk;

   row_shadow_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
      .req_write(req_write), .refresh_done(refresh_done), .status_wr(status_wr),
      .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_miss_clean(pred_miss_clean),
      .pred_miss_dirty(pred_miss_dirty), .nack_expected(nack_expected),
      .out_of_range(out_of_range), .retry_delay(retry_delay),
      .retry_pending(retry_pending), .resend(resend), .status_rd(status_rd)
   );

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   bit m_valid [NB];
   bit m_dirty [NB];
   int m_row   [NB];

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int model_status();
      int s = 0;
      for (int i = 0; i < NB; i++) begin
         if (m_valid[i]) s |= (1 << i);
         if (m_dirty[i]) s |= (1 << (NB + i));
      end
      return s;
   endfunction

   // outcome: 0 hit, 1 clean miss, 2 dirty miss
   function automatic int model_step(input int line, input bit wr, input bit rv,
                                     input bit rf, input bit sw);
      int  bank = (line >> 9) & 7;
      int  row  = line & 9'h1FF;
      bit  inr  = (line >> 12) == 0;
      int  outc = 0;
      if (rv && inr) begin
         if (m_valid[bank] && m_row[bank] == row) outc = 0;
         else outc = m_dirty[bank] ? 2 : 1;
      end
      if (sw) begin
         for (int i = 0; i < NB; i++) begin m_valid[i] = 0; m_dirty[i] = 1; end
      end else begin
         if (rv && inr) begin
            if (outc == 0) m_dirty[bank] = m_dirty[bank] | wr;
            else begin m_valid[bank] = 1; m_row[bank] = row; m_dirty[bank] = 0; end
         end
         if (rf) for (int i = 0; i < NB; i++) m_valid[i] = 0;
      end
      return outc;
   endfunction

   task automatic apply(input string req, input int line, input bit wr,
                        input bit rv, input bit rf, input bit sw);
      int  outc;
      bit  inr;
      int  dly;
      inr  = (line >> 12) == 0;
      outc = model_step(line, wr, rv, rf, sw);
      req_valid = rv; req_line = LINE_W'(line); req_write = wr;
      refresh_done = rf; status_wr = sw;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0; req_write = 0; refresh_done = 0; status_wr = 0;
      dly = (!rv || outc == 0) ? 0 : (outc == 2 ? DIRTY : CLEAN);
      check({req, " pred_valid"}, pred_valid, rv);
      check({req, " outcome"}, {pred_miss_dirty, pred_miss_clean, pred_hit},
            rv ? (1 << outc) : 0);
      check({req, " nack"}, nack_expected, rv && outc != 0);
      check({req, " R5 out_of_range"}, out_of_range, rv && !inr);
      check({req, " delay"}, retry_delay, dly);
      check({req, " R6 status"}, status_rd, model_status());
   endtask

   function automatic int mk(input int bank, input int row);
      return (bank << 9) | row;
   endfunction

   task automatic follow_timer(input string req, input int d);
      check({req, " pending at load"}, retry_pending, 1);
      check({req, " no early resend"}, resend, 0);
      for (int k = 1; k <= d; k++) begin
         @(posedge clk);
         @(negedge clk);
         check({req, " resend timing"}, resend, k == d);
         check({req, " pending window"}, retry_pending, k < d);
      end
   endtask

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'h5EED_0042);
      for (int i = 0; i < NB; i++) begin m_valid[i] = 0; m_dirty[i] = 0; m_row[i] = 0; end
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 status", status_rd, 0);
      check("R1 pred_valid", pred_valid, 0);
      check("R1 pending", retry_pending, 0);
      check("R1 resend", resend, 0);
      rst_n = 1;
      @(negedge clk);

      apply("R2 first open", mk(2, 5), 0, 1, 0, 0);
      follow_timer("R9 clean", CLEAN);
      apply("R3 read hit", mk(2, 5), 0, 1, 0, 0);
      apply("R3 write hit", mk(2, 5), 1, 1, 0, 0);
      apply("R4 dirty miss", mk(2, 7), 0, 1, 0, 0);
      follow_timer("R9 dirty", DIRTY);
      apply("R5 untracked", 32'h0480 | (1 << 12), 1, 1, 0, 0);
      apply("R5 untracked high", 32'h7FFF, 0, 1, 0, 0);
      apply("R3 make dirty", mk(2, 7), 1, 1, 0, 0);
      apply("R8 refresh", 0, 0, 0, 1, 0);
      apply("R8 refresh with open", mk(4, 1), 0, 1, 1, 0);
      apply("R7 force with req", mk(6, 3), 1, 1, 1, 1);
      apply("R7 miss after force", mk(0, 0), 0, 1, 0, 0);
      // R9 reload by a second miss
      apply("R9 first", mk(1, 9), 0, 1, 0, 0);
      apply("R9 second", mk(3, 9), 0, 1, 0, 0);
      apply("R9 reload", mk(5, 9), 0, 1, 0, 0);
      follow_timer("R9 reload", DIRTY);

      for (int n = 0; n < 400; n++) begin
         int  r    = int'($urandom_range(0, 99));
         int  line;
         bit  rv   = r < 85;
         bit  rf   = (r >= 85 && r < 95) || (r % 17 == 0);
         bit  sw   = r >= 97;
         if ($urandom_range(0, 9) == 0)
            line = int'($urandom_range(1 << 12, (1 << LINE_W) - 1));
         else
            line = mk(int'($urandom_range(0, NB - 1)), int'($urandom_range(0, 3)));
         apply("R2/R3/R4 random", line, 1'($urandom_range(0, 1)), rv, rf, sw);
      end

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule